// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Grant Parking

This block decides which of several bus nodes (by default four processors and one I/O bridge) owns a shared system bus. It hands out one-hot grants in rotating order, so that every requester is served fairly. It does not look at requests all the time. While a transaction runs, requests are sampled only in that transaction's final cycle. The length of the transaction comes from a read/write indication that the current master gives when it starts.

When no one is waiting at the end of a transaction, the arbiter parks a pregrant on the node that just used the bus. That node can start its next transaction in the very next cycle with no arbitration step, so a single busy node can stream back-to-back transactions. If another node requests while the bus is parked, its grant and the removal of the pregrant happen in the same cycle, so unparking costs nothing. A node that withdraws its request before it starts is never given the bus, and no empty transaction is issued for it.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant` is all zeros, `busy` is low and `pregrant` is 1 on node 0 only (value 1).
- R2: `grant` and `pregrant` each have at most one bit set, and they are never non-zero in the same cycle.
- R3: In an idle cycle with at least one request and no `xfer_start`, the next cycle shows a grant to the winner, and `pregrant` is zero in that same cycle.
- R4: The winner is the first requesting node at or after the position following the node that last received the bus (by grant or by starting on a pregrant), wrapping from the highest index to 0. After reset the search starts at node 1.
- R5: A transaction begins in the cycle the node holding the grant or pregrant asserts `xfer_start`. `busy` is then high for 3 following cycles for a read (`xfer_wr`=0) and 2 for a write (`xfer_wr`=1), so a transaction spans 4 or 3 cycles in total.
- R6: When a transaction ends with no requests in its last cycle, the next cycle shows `pregrant` on that transaction's master.
- R7: A node holding the pregrant may start without requesting. A start in an idle cycle wins over any requests in that cycle, and it counts as a grant for the rotation.
- R8: If a granted node drops its request before asserting `xfer_start`, its grant is removed in the next cycle, `busy` stays low, and the pregrant returns to the previously parked node.
- R9: Requests are sampled only in idle cycles and in the last cycle of a transaction. A request raised and dropped between those points is never granted.
- R10: `xfer_start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NODES | Bus request, one bit per node |
| xfer_start | input | 1 | Current owner (granted or pregranted node) begins a transaction |
| xfer_wr | input | 1 | Transaction type with `xfer_start`: 1 write, 0 read |
| grant | output | NODES | One-hot bus grant, registered |
| pregrant | output | NODES | One-hot parked pregrant, registered |
| busy | output | 1 | Bus occupied by a transaction after its start cycle |

## Verification
The bench uses the default five nodes with read and write lengths of 4 and 3. An odd node count makes the rotation pointer wrap at a value that is not a power of two, and it lets a search pass over the unused pointer codes. The two different lengths place the sampling point at two different offsets from the start. The five-node width also allows scripted patterns that cover parking, unparking, withdrawal while granted, requests pulsed in the middle of a transaction, and full contention, followed by a long pseudo-random stretch.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GNT  = 2'd1,
    ST_BUSY = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NODES = 5,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [NODES-1:0] req,
  input  logic [IW-1:0]    start_pos,
  output logic             found,
  output logic [IW-1:0]    winner
);
  // Scan from the farthest offset down so the nearest requester wins.
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int k = NODES - 1; k >= 0; k--) begin
      int pos;
      pos = int'(start_pos) + k;
      if (pos >= NODES) pos = pos - NODES;
      if (req[pos]) begin
        found  = 1'b1;
        winner = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/arb_xact_timer.sv
module arb_xact_timer #(
  parameter int RD_LEN = 4,
  parameter int WR_LEN = 3,
  localparam int MAXL  = (RD_LEN > WR_LEN) ? RD_LEN : WR_LEN,
  localparam int CW    = $clog2(MAXL) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic is_wr,
  output logic last
);
  logic [CW-1:0] left_q;

  // Start cycle counts as cycle one; busy cycles follow until left hits zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= is_wr ? CW'(WR_LEN - 2) : CW'(RD_LEN - 2);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last = (left_q == '0);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NODES  = 5,
  parameter int RD_LEN = 4,
  parameter int WR_LEN = 3,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] req,
  input  logic             xfer_start,
  input  logic             xfer_wr,
  output logic [NODES-1:0] grant,
  output logic [NODES-1:0] pregrant,
  output logic             busy
);
  import arb_pkg::*;

  arb_state_e     st_q, st_n;
  logic [IW-1:0]  owner_q, owner_n;
  logic [IW-1:0]  park_q, park_n;
  logic [IW-1:0]  ptr_q, ptr_n;
  logic           pick_found;
  logic [IW-1:0]  pick_idx;
  logic           tmr_load;
  logic           tmr_last;
  logic [NODES-1:0] grant_q, pregrant_q;
  logic           busy_q;

  function automatic logic [IW-1:0] next_pos(input logic [IW-1:0] p);
    return (p == IW'(NODES - 1)) ? '0 : p + 1'b1;
  endfunction

  arb_rr_pick #(.NODES(NODES)) u_pick (
    .req       (req),
    .start_pos (ptr_q),
    .found     (pick_found),
    .winner    (pick_idx)
  );

  arb_xact_timer #(.RD_LEN(RD_LEN), .WR_LEN(WR_LEN)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_load),
    .is_wr (xfer_wr),
    .last  (tmr_last)
  );

  always_comb begin
    st_n     = st_q;
    owner_n  = owner_q;
    park_n   = park_q;
    ptr_n    = ptr_q;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (xfer_start) begin
          st_n     = ST_BUSY;
          owner_n  = park_q;
          ptr_n    = next_pos(park_q);
          tmr_load = 1'b1;
        end else if (pick_found) begin
          st_n    = ST_GNT;
          owner_n = pick_idx;
          ptr_n   = next_pos(pick_idx);
        end
      end
      ST_GNT: begin
        if (xfer_start) begin
          st_n     = ST_BUSY;
          tmr_load = 1'b1;
        end else if (!req[owner_q]) begin
          st_n = ST_IDLE;
        end
      end
      ST_BUSY: begin
        if (tmr_last) begin
          park_n = owner_q;
          if (pick_found) begin
            st_n    = ST_GNT;
            owner_n = pick_idx;
            ptr_n   = next_pos(pick_idx);
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      owner_q    <= '0;
      park_q     <= '0;
      ptr_q      <= IW'(1 % NODES);
      grant_q    <= '0;
      pregrant_q <= NODES'(1);
      busy_q     <= 1'b0;
    end else begin
      st_q       <= st_n;
      owner_q    <= owner_n;
      park_q     <= park_n;
      ptr_q      <= ptr_n;
      grant_q    <= (st_n == ST_GNT)  ? (NODES'(1) << owner_n) : '0;
      pregrant_q <= (st_n == ST_IDLE) ? (NODES'(1) << park_n)  : '0;
      busy_q     <= (st_n == ST_BUSY);
    end
  end

  assign grant    = grant_q;
  assign pregrant = pregrant_q;
  assign busy     = busy_q;

  // R2: single owner on the bus
  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  assert_no_dual_owner_R2: assert property (@(posedge clk) disable iff (rst)
    !((|grant_q) && (|pregrant_q)));
  // R3: unpark and grant in one step
  assert_unpark_same_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !xfer_start && (|req)) |=> ((|grant_q) && !(|pregrant_q)));
  // R6: park on the master that just finished
  assert_park_last_master_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY && tmr_last && !(|req)) |=> (pregrant_q == (NODES'(1) << $past(owner_q))));
  // R8: withdrawn request loses its grant
  assert_withdraw_release_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GNT && !xfer_start && !req[owner_q]) |=> (grant_q == '0 && !busy_q));
  // R9: a new grant only goes to a node that was requesting
  assert_grant_to_requester_R9: assert property (@(posedge clk) disable iff (rst)
    ((|grant_q) && grant_q != $past(grant_q)) |-> (|(grant_q & $past(req))));
  // R10: a running transaction cannot be restarted
  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY && !tmr_last) |=> busy_q);
endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
  localparam int N  = 5;
  localparam int RD = 4;
  localparam int WR = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         xfer_start = 1'b0;
  logic         xfer_wr = 1'b0;
  logic [N-1:0] grant, pregrant;
  logic         busy;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit armed = 1'b0;
  bit done = 1'b0;

  // behavioural reference: 0 idle, 1 granted, 2 transferring
  int m_st, m_owner, m_park, m_ptr, m_left;

  always #4 clk = ~clk;

  bus_arbiter #(.NODES(N), .RD_LEN(RD), .WR_LEN(WR)) u0 (
    .clk(clk), .rst(rst), .req(req), .xfer_start(xfer_start), .xfer_wr(xfer_wr),
    .grant(grant), .pregrant(pregrant), .busy(busy)
  );

  function automatic int pick(input logic [N-1:0] r, input int from);
    for (int k = 0; k < N; k++) begin
      if (r[(from + k) % N]) return (from + k) % N;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    int w;
    armed = 1'b1;
    if (rst) begin
      m_st = 0; m_park = 0; m_ptr = 1; m_left = 0; m_owner = 0;
    end else begin
      case (m_st)
        0: begin
          w = pick(req, m_ptr);
          if (xfer_start) begin
            m_st = 2; m_owner = m_park; m_ptr = (m_park + 1) % N;
            m_left = (xfer_wr ? WR : RD) - 1;
          end else if (w >= 0) begin
            m_st = 1; m_owner = w; m_ptr = (w + 1) % N;
          end
        end
        1: begin
          if (xfer_start) begin
            m_st = 2; m_left = (xfer_wr ? WR : RD) - 1;
          end else if (!req[m_owner]) begin
            m_st = 0;
          end
        end
        default: begin
          if (m_left == 1) begin
            m_park = m_owner;
            w = pick(req, m_ptr);
            if (w >= 0) begin
              m_st = 1; m_owner = w; m_ptr = (w + 1) % N;
            end else begin
              m_st = 0;
            end
          end else begin
            m_left = m_left - 1;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    logic [N-1:0] eg, ep;
    logic eb;
    if (armed && !done) begin
      eg = (m_st == 1) ? (N'(1) << m_owner) : '0;
      ep = (m_st == 0) ? (N'(1) << m_park) : '0;
      eb = (m_st == 2);
      n_cmp++;
      if (grant !== eg || pregrant !== ep || busy !== eb) begin
        n_bad++;
        $display("FAIL %s: grant=%b pregrant=%b busy=%b expected grant=%b pregrant=%b busy=%b",
                 tag, grant, pregrant, busy, eg, ep, eb);
      end
    end
  end

  task automatic cyc(input logic [N-1:0] r, input bit s, input bit w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = r; xfer_start = s; xfer_wr = w;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    tag = "R1";
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 1'b0;
    cyc('0, 0, 0, 2);
    // R7 and R5: parked node 0 streams a read then a write
    tag = "R7"; cyc('0, 1, 0, 1);
    tag = "R5"; cyc('0, 0, 0, 3);
    tag = "R7"; cyc('0, 1, 1, 1);
    tag = "R5"; cyc('0, 0, 0, 3);
    // R3 and R4: nodes 2 and 4 request, search starts after node 0
    tag = "R3"; cyc(5'b10100, 0, 0, 1);
    tag = "R4"; cyc(5'b10100, 0, 0, 1);
    cyc(5'b10100, 1, 1, 1);
    // R9 and R10: node 1 pulses mid-transfer, restart attempts ignored
    tag = "R9";  cyc(5'b00010, 1, 0, 1);
    tag = "R10"; cyc(5'b10000, 1, 0, 1);
    // R8: node 4 withdraws before starting, bus parks on node 2
    tag = "R8"; cyc('0, 0, 0, 1);
    tag = "R6"; cyc('0, 0, 0, 3);
    // R4 full contention rotation with mixed lengths
    tag = "R4";
    for (int i = 0; i < 40; i++) cyc('1, 1, i[0], 1);
    for (int i = 0; i < 30; i++) cyc(5'b01001, 1, i[1], 1);
    // R7: start wins over requests on an idle bus
    tag = "R7"; cyc('0, 0, 0, 6); cyc(5'b00110, 1, 0, 1); cyc('0, 0, 0, 6);
    // R2 pseudo-random stretch
    tag = "R2";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[4:0] & lfsr[9:5], lfsr[11] | lfsr[12], lfsr[13], 1);
    end
    cyc('0, 0, 0, 8);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule